// File: doc/BRIEF.md
# Page Bank Select Controller

This block tracks which bank of program memory is switched into each page of a 16-page address space, where every page spans 4K words. It snoops the instruction stream: every executed 10-bit opcode is presented together with the number of the page it was fetched from. When the opcode is one of the four bank-enable codes, the controller records the chosen bank for the executing page. If that page has a fixed partner page, the partner is updated in the same cycle.

A separate access port takes a page number and returns, one clock later, the bank currently held for that page. An external address mapper combines this bank with the page and offset to form the physical address. The three lowest pages hold the operating system and always read bank 1. The upper eight pages are tied in even/odd pairs. Pages 3 and 5 are tied to each other, so that code in page 3 can switch a bank and then jump into page 5. Pages 4, 6 and 7 each switch alone.

A build-time parameter selects module-wide switching instead of per-page switching. In that mode one bank-enable changes every switchable page at once.

Top module: `page_bank_ctl`

## Requirements
- R1: After a synchronous reset every page reads bank code 2'b00, which stands for bank 1.
- R2: When `op_valid` is high, opcode 10'h100 selects code 2'b00, 10'h180 selects 2'b01, 10'h140 selects 2'b10 and 10'h1C0 selects 2'b11.
- R3: Pages 0, 1 and 2 always read 2'b00. A bank-enable opcode executed from one of these pages changes no page.
- R4: Pages 8/9, 10/11, 12/13 and 14/15 are paired. A bank-enable executed from either page of a pair sets both pages to the same code.
- R5: Pages 3 and 5 are paired. A bank-enable executed from either of them sets both.
- R6: Pages 4, 6 and 7 switch individually. A bank-enable executed from one of them leaves every other page unchanged.
- R7: An opcode other than the four bank-enable codes, or any opcode presented while `op_valid` is low, changes no page.
- R8: `acc_bank` is registered. It shows the bank held for the `acc_page` sampled at the previous rising edge. A bank-enable accepted at edge k is reflected for an access sampled at edge k+1 or later, and not for an access sampled at edge k.
- R9: With MODULE_WIDE=1, a bank-enable executed from any page from 3 to 15 sets every page from 3 to 15 to its code. Pages 0 to 2 stay at 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Strobe: `op_code` executed this cycle |
| op_code | input | 10 | Executed opcode |
| op_page | input | 4 | Page the opcode was fetched from |
| acc_page | input | 4 | Page being accessed |
| acc_bank | output | 2 | Registered bank code for the accessed page |

## Verification
The bench targets the linking corners. It tests the odd 3/5 pair from both sides, every even/odd upper pair from both sides, and the standalone pages 4, 6 and 7. A design with a wrong partner table would leave a partner stale or disturb a neighbour. Enables issued from operating-system pages must be dropped; a design that missed this would move pages 0 to 2 or their would-be partners. All four opcode encodings are checked, along with near-miss opcodes and a dropped strobe, to catch a loose decoder. The one-cycle visibility rule is probed by issuing an enable in the same cycle as an access to the same page, which catches an output that bypasses the bank registers.

// File: rtl/page_bank_pkg.sv
package page_bank_pkg;
  localparam int BANK_W = 2;
  typedef logic [BANK_W-1:0] bank_t;

  localparam logic [9:0] OP_BANK1 = 10'h100;
  localparam logic [9:0] OP_BANK2 = 10'h180;
  localparam logic [9:0] OP_BANK3 = 10'h140;
  localparam logic [9:0] OP_BANK4 = 10'h1C0;

  localparam int OS_PAGES = 3;
endpackage

// File: rtl/bank_op_decode.sv
module bank_op_decode
  import page_bank_pkg::*;
#(
  parameter int OP_W = 10
) (
  input  logic            op_valid,
  input  logic [OP_W-1:0] op_code,
  output logic            hit,
  output bank_t           bank
);
  always_comb begin
    hit  = 1'b0;
    bank = '0;
    if (op_valid) begin
      unique case (op_code)
        OP_BANK1: begin hit = 1'b1; bank = 2'b00; end
        OP_BANK2: begin hit = 1'b1; bank = 2'b01; end
        OP_BANK3: begin hit = 1'b1; bank = 2'b10; end
        OP_BANK4: begin hit = 1'b1; bank = 2'b11; end
        default:  begin hit = 1'b0; bank = '0; end
      endcase
    end
  end
endmodule

// File: rtl/bank_link_map.sv
module bank_link_map
  import page_bank_pkg::*;
#(
  parameter int NUM_PAGES   = 16,
  parameter bit MODULE_WIDE = 1'b0,
  localparam int PAGE_W     = $clog2(NUM_PAGES)
) (
  input  logic [PAGE_W-1:0]    exec_page,
  output logic [NUM_PAGES-1:0] mask
);
  logic exec_sw;
  assign exec_sw = (exec_page >= PAGE_W'(OS_PAGES));

  generate
    if (MODULE_WIDE) begin : g_wide
      always_comb begin
        for (int p = 0; p < NUM_PAGES; p++)
          mask[p] = exec_sw && (p >= OS_PAGES);
      end
    end else begin : g_page
      logic [PAGE_W-1:0] partner;
      always_comb begin
        if (exec_page == PAGE_W'(3))      partner = PAGE_W'(5);
        else if (exec_page == PAGE_W'(5)) partner = PAGE_W'(3);
        else if (exec_page >= PAGE_W'(8)) partner = exec_page ^ PAGE_W'(1);
        else                              partner = exec_page;
      end
      always_comb begin
        for (int p = 0; p < NUM_PAGES; p++)
          mask[p] = exec_sw &&
                    ((PAGE_W'(p) == exec_page) || (PAGE_W'(p) == partner));
      end
    end
  endgenerate
endmodule

// File: rtl/bank_reg_file.sv
module bank_reg_file
  import page_bank_pkg::*;
#(
  parameter int NUM_PAGES = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [NUM_PAGES-1:0]  wr_mask,
  input  bank_t                 wr_bank,
  output bank_t [NUM_PAGES-1:0] banks
);
  always_ff @(posedge clk) begin
    if (rst) begin
      banks <= '0;
    end else if (wr_en) begin
      for (int p = 0; p < NUM_PAGES; p++)
        if (wr_mask[p]) banks[p] <= wr_bank;
    end
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(banks)); // R7
endmodule

// File: rtl/page_bank_ctl.sv
module page_bank_ctl
  import page_bank_pkg::*;
#(
  parameter int NUM_PAGES   = 16,
  parameter int OP_W        = 10,
  parameter bit MODULE_WIDE = 1'b0,
  localparam int PAGE_W     = $clog2(NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_code,
  input  logic [PAGE_W-1:0] op_page,
  input  logic [PAGE_W-1:0] acc_page,
  output logic [1:0]        acc_bank
);
  logic                  dec_hit;
  bank_t                 dec_bank;
  logic [NUM_PAGES-1:0]  link_mask;
  bank_t [NUM_PAGES-1:0] bank_q;

  bank_op_decode #(.OP_W(OP_W)) u_dec (
    .op_valid (op_valid),
    .op_code  (op_code),
    .hit      (dec_hit),
    .bank     (dec_bank)
  );

  bank_link_map #(.NUM_PAGES(NUM_PAGES), .MODULE_WIDE(MODULE_WIDE)) u_link (
    .exec_page (op_page),
    .mask      (link_mask)
  );

  bank_reg_file #(.NUM_PAGES(NUM_PAGES)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (dec_hit),
    .wr_mask (link_mask),
    .wr_bank (dec_bank),
    .banks   (bank_q)
  );

  always_ff @(posedge clk) begin
    if (rst) acc_bank <= '0;
    else     acc_bank <= bank_q[acc_page];
  end

  generate
    for (genvar g = 0; g < OS_PAGES; g++) begin : g_os_chk
      AST_OS_FIXED: assert property (@(posedge clk) disable iff (rst)
        bank_q[g] == 2'b00); // R3
    end
    for (genvar g = 8; g < NUM_PAGES; g += 2) begin : g_pair_chk
      AST_PAIR_EQUAL: assert property (@(posedge clk) disable iff (rst)
        bank_q[g] == bank_q[g+1]); // R4
    end
    if (!MODULE_WIDE) begin : g_solo_chk
      AST_SOLO_ISOLATED: assert property (@(posedge clk) disable iff (rst)
        (dec_hit && op_page == PAGE_W'(4)) |=> $stable(bank_q[7]) && $stable(bank_q[6])); // R6
    end
  endgenerate

  AST_LOW_PAIR_EQUAL: assert property (@(posedge clk) disable iff (rst)
    bank_q[3] == bank_q[5]); // R5
endmodule

// File: tb/sim_page_bank_ctl.sv
module sim_page_bank_ctl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       op_valid;
  logic [9:0] op_code;
  logic [3:0] op_page;
  logic [3:0] acc_page;
  logic [1:0] acc_bank;
  logic [1:0] acc_bank_w;

  int n_chk = 0;
  int n_bad = 0;
  logic [1:0] model [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  page_bank_ctl u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_page(op_page), .acc_page(acc_page), .acc_bank(acc_bank)
  );

  page_bank_ctl #(.MODULE_WIDE(1'b1)) u1 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_page(op_page), .acc_page(acc_page), .acc_bank(acc_bank_w)
  );

  task automatic check(string req, logic [1:0] got, logic [1:0] exp, int pg);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s page %0d: got %0b expected %0b", req, pg, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; op_valid = 1'b0; op_code = '0; op_page = '0; acc_page = '0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    for (int p = 0; p < 16; p++) model[p] = 2'b00;
  endtask

  task automatic exec_op(logic [9:0] op, logic [3:0] pg, logic vld);
    @(negedge clk);
    op_valid = vld; op_code = op; op_page = pg;
    @(negedge clk);
    op_valid = 1'b0; op_code = '0;
  endtask

  function automatic logic [3:0] partner_of(int p);
    if (p == 3) return 4'd5;
    if (p == 5) return 4'd3;
    if (p >= 8) return 4'(p ^ 1);
    return 4'(p);
  endfunction

  task automatic apply_model(logic [1:0] b, int pg);
    if (pg >= 3) begin
      model[pg] = b;
      model[partner_of(pg)] = b;
    end
  endtask

  task automatic check_all(string req);
    for (int p = 0; p < 16; p++) begin
      acc_page = 4'(p);
      @(negedge clk);
      check(req, acc_bank, model[p], p);
    end
  endtask

  task automatic t_reset();
    do_reset();
    check_all("R1");
  endtask

  task automatic t_encodings();
    logic [9:0] ops [4] = '{10'h100, 10'h180, 10'h140, 10'h1C0};
    do_reset();
    for (int i = 0; i < 4; i++) begin
      exec_op(ops[i], 4'd4, 1'b1);
      model[4] = 2'(i);
      acc_page = 4'd4;
      @(negedge clk);
      check("R2", acc_bank, model[4], 4);
    end
  endtask

  task automatic t_os_pages();
    do_reset();
    for (int p = 0; p < 3; p++) exec_op(10'h1C0, 4'(p), 1'b1);
    check_all("R3");
  endtask

  task automatic t_upper_pairs();
    do_reset();
    for (int p = 8; p < 16; p++) begin
      logic [1:0] b = 2'((p + 1) % 4);
      exec_op((b == 2'd0) ? 10'h100 : (b == 2'd1) ? 10'h180 :
              (b == 2'd2) ? 10'h140 : 10'h1C0, 4'(p), 1'b1);
      apply_model(b, p);
      check_all("R4");
    end
  endtask

  task automatic t_low_pair();
    do_reset();
    exec_op(10'h180, 4'd3, 1'b1); apply_model(2'd1, 3);
    check_all("R5");
    exec_op(10'h1C0, 4'd5, 1'b1); apply_model(2'd3, 5);
    check_all("R5");
  endtask

  task automatic t_solo();
    do_reset();
    exec_op(10'h140, 4'd4, 1'b1); apply_model(2'd2, 4);
    exec_op(10'h1C0, 4'd6, 1'b1); apply_model(2'd3, 6);
    exec_op(10'h180, 4'd7, 1'b1); apply_model(2'd1, 7);
    check_all("R6");
  endtask

  task automatic t_ignored();
    do_reset();
    exec_op(10'h180, 4'd9, 1'b1); apply_model(2'd1, 9);
    exec_op(10'h1C0, 4'd9, 1'b0);
    exec_op(10'h101, 4'd9, 1'b1);
    exec_op(10'h1C8, 4'd3, 1'b1);
    exec_op(10'h300, 4'd4, 1'b1);
    check_all("R7");
  endtask

  task automatic t_timing();
    do_reset();
    @(negedge clk);
    op_valid = 1'b1; op_code = 10'h1C0; op_page = 4'd12; acc_page = 4'd13;
    @(negedge clk);
    op_valid = 1'b0; op_code = '0;
    check("R8", acc_bank, 2'b00, 13);
    @(negedge clk);
    check("R8", acc_bank, 2'b11, 13);
    model[12] = 2'b11; model[13] = 2'b11;
  endtask

  task automatic t_module_wide();
    do_reset();
    exec_op(10'h140, 4'd7, 1'b1);
    for (int p = 0; p < 16; p++) begin
      acc_page = 4'(p);
      @(negedge clk);
      check("R9", acc_bank_w, (p >= 3) ? 2'b10 : 2'b00, p);
    end
    exec_op(10'h180, 4'd1, 1'b1);
    acc_page = 4'd15;
    @(negedge clk);
    check("R9", acc_bank_w, 2'b10, 15);
  endtask

  initial begin
    rst = 1'b1; op_valid = 1'b0; op_code = '0; op_page = '0; acc_page = '0;
    t_reset();
    t_encodings();
    t_os_pages();
    t_upper_pairs();
    t_low_pair();
    t_solo();
    t_ignored();
    t_timing();
    t_module_wide();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule